// File: doc/BRIEF.md
# LCD Controller Bring-Up Sequencer

This block drives a small external LCD controller from reset to a state where it accepts pixel memory writes. It does not shift bits itself. It issues one register transaction at a time to a separate register engine, which does the serial framing. Each transaction carries an operation code, a register index and a 16-bit data word. The engine answers with a one-cycle `reg_done`, returning read data and an error flag.

A `start` pulse runs the full bring-up:
- an identity read, accepted only when the masked ID matches;
- a status read;
- oscillator start;
- the configuration writes;
- the embedded power-on sequence;
- gamma and window setup.

The last step is an index-only transaction that selects the pixel-memory data register. All waits are counted in pulses of a free-running millisecond tick. Every step comes from a constant step table, so the sequencing logic does not depend on the values in it.

Once up, the block runs the power-on or power-off sequence on request, but only when the request changes the recorded on/off state. Any transport error, and any identity mismatch, stops the block with `fault` set. A new `start` is the only way out of that state.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is held and after its release, `ready`, `fault`, `powered` and `reg_req` are 0, and no transaction is requested until a command arrives.
- R2: The first transaction after `start` is a register read (`reg_op`=1) of index 0x00. If `reg_err` is 0 and `(reg_rdata & 0xFFF0) == 0x9220`, the sequence continues. Otherwise `fault` rises, `ready` and `powered` stay 0, and no further transaction is issued. `ready` and `fault` are never both 1.
- R3: After an accepted ID, the block issues a status read (`reg_op`=2, index 0x00). It then issues writes (`reg_op`=0) with these index=data pairs:
  - 00=0001;
  - 01=691B, 02=0700, 03=1030, 04=0000, 05=0000, 07=0037, 08=0202, 09=0000, 0B=0000, 0C=0110;
  - the R4 power-on list;
  - 30..39 = 0302, 0407, 0304, 0203, 0706, 0407, 0706, 0000, 0C06, 0F00;
  - 21=0000, 40=0000, 41=0000, 42=DB00, 43=DB00, 44=AF00, 45=DB00.
- R4: The power-on list writes, in order: 10=0000, 11=0000, 12=0000, 13=0000, 56=080F, 10=4240, 11=0000, 12=0014, 13=1319.
- R5: After the `reg_done` of a write to index 0x10 or to 0x00=0001, the next request, or sequence completion, waits exactly 10 `ms_tick` pulses. After index 0x12 or 0x13 it waits exactly 40 pulses. After any other step there is no wait.
- R6: The final bring-up step is index-only (`reg_op`=3) with index 0x22. On its completion `ready` and `powered` become 1.
- R7: A power-off request writes zero to 0x10, 0x11, 0x12 and 0x13 in that order, with the R5 waits, and then clears `powered`. The completion cycle shows `ready`=1.
- R8: A power request acts only while `ready` is 1. `pwr_on_req` starts the R4 list only when `powered` is 0. `pwr_off_req` starts R7 only when `powered` is 1. Any other request issues no transaction and changes nothing. With both asserted, only the one that changes the state runs.
- R9: A `reg_err` on any `reg_done` ends the running sequence. `fault` becomes 1, `ready` becomes 0, and `powered` keeps its value from before the sequence.
- R10: `start` is ignored while a sequence runs. From idle, including after a fault, `start` clears `fault` and `powered` and restarts bring-up. Power requests issue nothing while `fault` is 1.
- R11: `reg_req` stays high, with `reg_op`, `reg_addr` and `reg_wdata` stable, until the cycle in which `reg_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin full bring-up (pulse) |
| pwr_on_req | input | 1 | Request the power-on sequence |
| pwr_off_req | input | 1 | Request the power-off sequence |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| reg_req | output | 1 | Transaction request to the register engine |
| reg_op | output | 2 | 0 write, 1 register read, 2 status read, 3 index only |
| reg_addr | output | 8 | Register index |
| reg_wdata | output | 16 | Write data |
| reg_done | input | 1 | Engine finished the current transaction |
| reg_err | input | 1 | Engine reports a transport error with `reg_done` |
| reg_rdata | input | 16 | Read data valid with `reg_done` |
| ready | output | 1 | Bring-up complete, block idle |
| fault | output | 1 | Sequence stopped by error or ID mismatch |
| powered | output | 1 | Recorded panel power state |

## Verification
The identity check is swept over all sixteen low-nibble values, which must all pass, and over a single flipped bit in each masked position, which must all fail. This shows that the mask and the compared value are both applied.

Complete bring-up, power-off and power-on runs are compared transaction by transaction against the listed pairs. The tick count between each completion and the next request is measured, which separates the 10 ms and 40 ms waits and also catches any off-by-one.

Repeated, simultaneous and mid-sequence commands show that only state-changing requests act. Injected engine errors, in both a power sequence and bring-up, show that `powered` is preserved and that the block recovers only through `start`.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int STEP_W = 6;

    // Step table layout: sequence boundaries that the control logic follows
    localparam logic [STEP_W-1:0] STEP_INIT_FIRST  = 6'd0;
    localparam logic [STEP_W-1:0] STEP_PON_FIRST   = 6'd13;
    localparam logic [STEP_W-1:0] STEP_PON_LAST    = 6'd21;
    localparam logic [STEP_W-1:0] STEP_GAMMA_FIRST = 6'd22;
    localparam logic [STEP_W-1:0] STEP_GAMMA_LAST  = 6'd31;
    localparam logic [STEP_W-1:0] STEP_INIT_LAST   = 6'd39;
    localparam logic [STEP_W-1:0] STEP_POFF_FIRST  = 6'd40;
    localparam logic [STEP_W-1:0] STEP_POFF_LAST   = 6'd43;

    // Gamma tuning words, entry 0 goes to index 0x30
    localparam logic [9:0][15:0] GAMMA_ROM = {
        16'h0F00, 16'h0C06, 16'h0000, 16'h0706, 16'h0407,
        16'h0706, 16'h0203, 16'h0304, 16'h0407, 16'h0302
    };

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_STATUS = 2'd2,
        OP_INDEX  = 2'd3
    } reg_op_e;

    typedef enum logic [1:0] {
        DLY_NONE  = 2'd0,
        DLY_SHORT = 2'd1,
        DLY_LONG  = 2'd2
    } dly_e;

    typedef enum logic [1:0] {
        SEQ_INIT = 2'd0,
        SEQ_PON  = 2'd1,
        SEQ_POFF = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DELAY = 2'd2
    } state_e;

    typedef struct packed {
        reg_op_e     op;
        logic [7:0]  addr;
        logic [15:0] data;
        dly_e        dly;
    } step_t;

    typedef struct packed {
        state_e            state;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] last;
        seq_e              seq;
        logic              ready;
        logic              fault;
        logic              powered;
    } ctl_t;

    function automatic step_t mk(reg_op_e op, logic [7:0] a, logic [15:0] d, dly_e w);
        step_t e;
        e.op   = op;
        e.addr = a;
        e.data = d;
        e.dly  = w;
        return e;
    endfunction

    function automatic step_t step_lookup(logic [STEP_W-1:0] s);
        step_t             e;
        logic [STEP_W-1:0] gi;
        gi = s - STEP_GAMMA_FIRST;
        e  = mk(OP_WRITE, 8'h00, 16'h0000, DLY_NONE);
        if (s >= STEP_GAMMA_FIRST && s <= STEP_GAMMA_LAST) begin
            e = mk(OP_WRITE, 8'h30 + {2'b00, gi}, GAMMA_ROM[gi[3:0]], DLY_NONE);
        end else begin
            case (s)
                6'd0:  e = mk(OP_READ,   8'h00, 16'h0000, DLY_NONE);
                6'd1:  e = mk(OP_STATUS, 8'h00, 16'h0000, DLY_NONE);
                6'd2:  e = mk(OP_WRITE,  8'h00, 16'h0001, DLY_SHORT);
                6'd3:  e = mk(OP_WRITE,  8'h01, 16'h691B, DLY_NONE);
                6'd4:  e = mk(OP_WRITE,  8'h02, 16'h0700, DLY_NONE);
                6'd5:  e = mk(OP_WRITE,  8'h03, 16'h1030, DLY_NONE);
                6'd6:  e = mk(OP_WRITE,  8'h04, 16'h0000, DLY_NONE);
                6'd7:  e = mk(OP_WRITE,  8'h05, 16'h0000, DLY_NONE);
                6'd8:  e = mk(OP_WRITE,  8'h07, 16'h0037, DLY_NONE);
                6'd9:  e = mk(OP_WRITE,  8'h08, 16'h0202, DLY_NONE);
                6'd10: e = mk(OP_WRITE,  8'h09, 16'h0000, DLY_NONE);
                6'd11: e = mk(OP_WRITE,  8'h0B, 16'h0000, DLY_NONE);
                6'd12: e = mk(OP_WRITE,  8'h0C, 16'h0110, DLY_NONE);
                6'd13: e = mk(OP_WRITE,  8'h10, 16'h0000, DLY_SHORT);
                6'd14: e = mk(OP_WRITE,  8'h11, 16'h0000, DLY_NONE);
                6'd15: e = mk(OP_WRITE,  8'h12, 16'h0000, DLY_LONG);
                6'd16: e = mk(OP_WRITE,  8'h13, 16'h0000, DLY_LONG);
                6'd17: e = mk(OP_WRITE,  8'h56, 16'h080F, DLY_NONE);
                6'd18: e = mk(OP_WRITE,  8'h10, 16'h4240, DLY_SHORT);
                6'd19: e = mk(OP_WRITE,  8'h11, 16'h0000, DLY_NONE);
                6'd20: e = mk(OP_WRITE,  8'h12, 16'h0014, DLY_LONG);
                6'd21: e = mk(OP_WRITE,  8'h13, 16'h1319, DLY_LONG);
                6'd32: e = mk(OP_WRITE,  8'h21, 16'h0000, DLY_NONE);
                6'd33: e = mk(OP_WRITE,  8'h40, 16'h0000, DLY_NONE);
                6'd34: e = mk(OP_WRITE,  8'h41, 16'h0000, DLY_NONE);
                6'd35: e = mk(OP_WRITE,  8'h42, 16'hDB00, DLY_NONE);
                6'd36: e = mk(OP_WRITE,  8'h43, 16'hDB00, DLY_NONE);
                6'd37: e = mk(OP_WRITE,  8'h44, 16'hAF00, DLY_NONE);
                6'd38: e = mk(OP_WRITE,  8'h45, 16'hDB00, DLY_NONE);
                6'd39: e = mk(OP_INDEX,  8'h22, 16'h0000, DLY_NONE);
                6'd40: e = mk(OP_WRITE,  8'h10, 16'h0000, DLY_SHORT);
                6'd41: e = mk(OP_WRITE,  8'h11, 16'h0000, DLY_NONE);
                6'd42: e = mk(OP_WRITE,  8'h12, 16'h0000, DLY_LONG);
                6'd43: e = mk(OP_WRITE,  8'h13, 16'h0000, DLY_LONG);
                default: e = mk(OP_WRITE, 8'h00, 16'h0000, DLY_NONE);
            endcase
        end
        return e;
    endfunction

endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
    import lcd_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output step_t             entry
);

    always_comb begin
        entry = step_lookup(step);
    end

endmodule

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Fires on the tick that completes the count, so the caller advances on it
    assign expire = tick && !load && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter logic [15:0] ID_VALUE = 16'h9220,
    parameter logic [15:0] ID_MASK  = 16'hFFF0,
    parameter int          SHORT_MS = 10,
    parameter int          LONG_MS  = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        pwr_on_req,
    input  logic        pwr_off_req,
    input  logic        ms_tick,
    output logic        reg_req,
    output logic [1:0]  reg_op,
    output logic [7:0]  reg_addr,
    output logic [15:0] reg_wdata,
    input  logic        reg_done,
    input  logic        reg_err,
    input  logic [15:0] reg_rdata,
    output logic        ready,
    output logic        fault,
    output logic        powered
);

    localparam int MAX_MS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    ctl_t             ctl_d, ctl_q;
    step_t            cur;
    logic             tmr_load;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_val;
    logic             id_bad;
    logic             adv;

    lcd_seq_rom u_rom (
        .step  (ctl_q.step),
        .entry (cur)
    );

    lcd_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (ms_tick),
        .expire   (tmr_expire)
    );

    assign tmr_val = (cur.dly == DLY_LONG) ? CNT_W'(LONG_MS) : CNT_W'(SHORT_MS);
    assign id_bad  = (cur.op == OP_READ) &&
                     ((reg_rdata & ID_MASK) != (ID_VALUE & ID_MASK));

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        adv      = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state   = ST_ISSUE;
                    ctl_d.step    = STEP_INIT_FIRST;
                    ctl_d.last    = STEP_INIT_LAST;
                    ctl_d.seq     = SEQ_INIT;
                    ctl_d.ready   = 1'b0;
                    ctl_d.fault   = 1'b0;
                    ctl_d.powered = 1'b0;
                end else if (ctl_q.ready && pwr_on_req && !ctl_q.powered) begin
                    ctl_d.state = ST_ISSUE;
                    ctl_d.step  = STEP_PON_FIRST;
                    ctl_d.last  = STEP_PON_LAST;
                    ctl_d.seq   = SEQ_PON;
                end else if (ctl_q.ready && pwr_off_req && ctl_q.powered) begin
                    ctl_d.state = ST_ISSUE;
                    ctl_d.step  = STEP_POFF_FIRST;
                    ctl_d.last  = STEP_POFF_LAST;
                    ctl_d.seq   = SEQ_POFF;
                end
            end
            ST_ISSUE: begin
                if (reg_done) begin
                    if (reg_err || id_bad) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.fault = 1'b1;
                        ctl_d.ready = 1'b0;
                    end else if (cur.dly != DLY_NONE) begin
                        ctl_d.state = ST_DELAY;
                        tmr_load    = 1'b1;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (tmr_expire) begin
                    adv = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (adv) begin
            if (ctl_q.step == ctl_q.last) begin
                ctl_d.state = ST_IDLE;
                case (ctl_q.seq)
                    SEQ_INIT: begin
                        ctl_d.ready   = 1'b1;
                        ctl_d.powered = 1'b1;
                    end
                    SEQ_PON:  ctl_d.powered = 1'b1;
                    default:  ctl_d.powered = 1'b0;
                endcase
            end else begin
                ctl_d.step  = ctl_q.step + 1'b1;
                ctl_d.state = ST_ISSUE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, step: '0, last: '0, seq: SEQ_INIT,
                       ready: 1'b0, fault: 1'b0, powered: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign reg_req   = (ctl_q.state == ST_ISSUE);
    assign reg_op    = cur.op;
    assign reg_addr  = cur.addr;
    assign reg_wdata = cur.data;
    assign ready     = ctl_q.ready && (ctl_q.state == ST_IDLE);
    assign fault     = ctl_q.fault;
    assign powered   = ctl_q.powered;

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk #(
    parameter logic [15:0] ID_VALUE = 16'h9220,
    parameter logic [15:0] ID_MASK  = 16'hFFF0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        pwr_on_req,
    input logic        pwr_off_req,
    input logic        reg_req,
    input logic [1:0]  reg_op,
    input logic [7:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        reg_done,
    input logic        reg_err,
    input logic [15:0] reg_rdata,
    input logic        ready,
    input logic        fault,
    input logic        powered
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_done |=> reg_req); // R11

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_done |=> $stable(reg_op) && $stable(reg_addr) && $stable(reg_wdata)); // R11

    AST_ID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_done && !reg_err && reg_op == 2'd1 &&
        ((reg_rdata & ID_MASK) != (ID_VALUE & ID_MASK)) |=> fault && !reg_req); // R2

    AST_READY_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && fault)); // R2

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_done && reg_err |=> fault && !reg_req); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ready || fault) |-> !reg_req); // R10

    AST_POWER_UP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |-> ready); // R6

    AST_POWER_DOWN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered) |-> ready || $past(start)); // R7

    AST_REDUNDANT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ready && powered && pwr_on_req && !pwr_off_req && !start
        |=> ready && powered && !reg_req); // R8

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk #(.ID_VALUE(ID_VALUE), .ID_MASK(ID_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pwr_on_req  (pwr_on_req),
    .pwr_off_req (pwr_off_req),
    .reg_req     (reg_req),
    .reg_op      (reg_op),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_done    (reg_done),
    .reg_err     (reg_err),
    .reg_rdata   (reg_rdata),
    .ready       (ready),
    .fault       (fault),
    .powered     (powered)
);

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n, start, pwr_on_req, pwr_off_req, ms_tick;
    logic        reg_req, reg_done, reg_err;
    logic [1:0]  reg_op;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        ready, fault, powered;

    int checks = 0;
    int fails  = 0;
    int tk     = 0;
    int n_tr   = 0;
    int err_at = -1;
    int tph    = 0;
    int t_end  = 0;
    logic [15:0] id_val = 16'h9221;

    logic [1:0]  lop [64];
    logic [7:0]  lad [64];
    logic [15:0] ldt [64];
    int          lreq [64];
    int          ldone [64];

    always #5 clk = ~clk;

    lcd_pwr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pwr_on_req(pwr_on_req),
        .pwr_off_req(pwr_off_req), .ms_tick(ms_tick), .reg_req(reg_req),
        .reg_op(reg_op), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_done(reg_done), .reg_err(reg_err), .reg_rdata(reg_rdata),
        .ready(ready), .fault(fault), .powered(powered)
    );

    // Millisecond tick: one cycle in three
    initial begin
        ms_tick = 1'b0;
        forever begin
            @(negedge clk);
            ms_tick = (tph == 0);
            tph = (tph + 1) % 3;
        end
    end

    always @(posedge clk) begin
        if (ms_tick) tk <= tk + 1;
    end

    // Register engine model: answers each request after one cycle
    initial begin
        reg_done  = 1'b0;
        reg_err   = 1'b0;
        reg_rdata = 16'h0000;
        forever begin
            @(negedge clk);
            if (reg_done) begin
                ldone[n_tr-1] = tk;
                reg_done = 1'b0;
                reg_err  = 1'b0;
            end
            if (reg_req && n_tr < 64) begin
                lop[n_tr]  = reg_op;
                lad[n_tr]  = reg_addr;
                ldt[n_tr]  = reg_wdata;
                lreq[n_tr] = tk;
                reg_rdata  = (reg_op == 2'd1) ? id_val : 16'h1234;
                reg_err    = (n_tr == err_at);
                n_tr       = n_tr + 1;
                reg_done   = 1'b1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_idle();
        cyc(1);
        while (!(ready || fault)) cyc(1);
        t_end = tk;
    endtask

    task automatic pulse_start();
        start = 1'b1; cyc(1); start = 1'b0;
    endtask

    task automatic pulse_on();
        pwr_on_req = 1'b1; cyc(1); pwr_on_req = 1'b0;
    endtask

    task automatic pulse_off();
        pwr_off_req = 1'b1; cyc(1); pwr_off_req = 1'b0;
    endtask

    // {op, index, data, wait ticks after completion}
    function automatic logic [33:0] e(int op, int a, int d, int t);
        return {2'(op), 8'(a), 16'(d), 8'(t)};
    endfunction

    function automatic logic [33:0] exp_pon(int i);
        case (i)
            0: return e(0, 'h10, 'h0000, 10);
            1: return e(0, 'h11, 'h0000, 0);
            2: return e(0, 'h12, 'h0000, 40);
            3: return e(0, 'h13, 'h0000, 40);
            4: return e(0, 'h56, 'h080F, 0);
            5: return e(0, 'h10, 'h4240, 10);
            6: return e(0, 'h11, 'h0000, 0);
            7: return e(0, 'h12, 'h0014, 40);
            default: return e(0, 'h13, 'h1319, 40);
        endcase
    endfunction

    function automatic logic [33:0] exp_init(int i);
        int gam [10] = '{'h0302, 'h0407, 'h0304, 'h0203, 'h0706,
                         'h0407, 'h0706, 'h0000, 'h0C06, 'h0F00};
        if (i >= 13 && i <= 21) return exp_pon(i - 13);
        if (i >= 22 && i <= 31) return e(0, 'h30 + i - 22, gam[i-22], 0);
        case (i)
            0:  return e(1, 'h00, 0, 0);
            1:  return e(2, 'h00, 0, 0);
            2:  return e(0, 'h00, 'h0001, 10);
            3:  return e(0, 'h01, 'h691B, 0);
            4:  return e(0, 'h02, 'h0700, 0);
            5:  return e(0, 'h03, 'h1030, 0);
            6:  return e(0, 'h04, 'h0000, 0);
            7:  return e(0, 'h05, 'h0000, 0);
            8:  return e(0, 'h07, 'h0037, 0);
            9:  return e(0, 'h08, 'h0202, 0);
            10: return e(0, 'h09, 'h0000, 0);
            11: return e(0, 'h0B, 'h0000, 0);
            12: return e(0, 'h0C, 'h0110, 0);
            32: return e(0, 'h21, 'h0000, 0);
            33: return e(0, 'h40, 'h0000, 0);
            34: return e(0, 'h41, 'h0000, 0);
            35: return e(0, 'h42, 'hDB00, 0);
            36: return e(0, 'h43, 'hDB00, 0);
            37: return e(0, 'h44, 'hAF00, 0);
            38: return e(0, 'h45, 'hDB00, 0);
            default: return e(3, 'h22, 0, 0);
        endcase
    endfunction

    // kind 0 bring-up, 1 power-on, 2 power-off
    function automatic logic [33:0] exp_any(int kind, int i);
        if (kind == 0) return exp_init(i);
        return exp_pon(i);
    endfunction

    task automatic check_seq(int kind, int count, string tag);
        logic [33:0] x;
        logic [33:0] p;
        chk({tag, " transaction count"}, n_tr, count);
        for (int i = 0; i < count && i < n_tr; i++) begin
            x = exp_any(kind, i);
            chk({tag, " op"}, lop[i], x[33:32]);
            chk({tag, " index"}, lad[i], x[31:24]);
            if (x[33:32] == 2'd0) chk({tag, " data"}, ldt[i], x[23:8]);
            if (i > 0) begin
                p = exp_any(kind, i - 1);
                chk("R5 wait before next step", lreq[i] - ldone[i-1], p[7:0]);
            end
        end
        if (n_tr == count) begin
            p = exp_any(kind, count - 1);
            chk("R5 wait before completion", t_end - ldone[count-1], p[7:0]);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; pwr_on_req = 1'b0; pwr_off_req = 1'b0;
        cyc(4);
        chk("R1 reset ready", ready, 0);
        chk("R1 reset fault", fault, 0);
        chk("R1 reset powered", powered, 0);
        chk("R1 reset req", reg_req, 0);
        rst_n = 1'b1;
        cyc(5);
        chk("R1 no request after reset", n_tr, 0);

        // Full bring-up
        n_tr = 0; id_val = 16'h9221;
        pulse_start(); wait_idle();
        check_seq(0, 40, "R3");
        chk("R6 last step index only", lop[39], 3);
        chk("R6 ready", ready, 1);
        chk("R6 powered", powered, 1);
        chk("R2 no fault", fault, 0);

        // Redundant power-on
        n_tr = 0; pulse_on(); cyc(30);
        chk("R8 redundant on issues nothing", n_tr, 0);
        chk("R8 powered kept", powered, 1);

        // Power-off
        n_tr = 0; pulse_off(); wait_idle();
        check_seq(2, 4, "R7");
        chk("R7 powered cleared", powered, 0);
        chk("R7 ready", ready, 1);

        n_tr = 0; pulse_off(); cyc(30);
        chk("R8 redundant off issues nothing", n_tr, 0);
        chk("R8 still off", powered, 0);

        // Power-on
        n_tr = 0; pulse_on(); wait_idle();
        check_seq(1, 9, "R4");
        chk("R4 powered set", powered, 1);

        // Both requests while on: only off runs
        n_tr = 0; pwr_on_req = 1'b1; pwr_off_req = 1'b1; cyc(1);
        pwr_on_req = 1'b0; pwr_off_req = 1'b0; wait_idle();
        chk("R8 both requests run off only", n_tr, 4);
        chk("R8 both requests result", powered, 0);
        n_tr = 0; pulse_on(); wait_idle();
        chk("R4 back on", powered, 1);

        // start while busy is ignored
        n_tr = 0; pulse_start();
        while (n_tr < 10) cyc(1);
        pulse_start(); wait_idle();
        chk("R10 start ignored while busy", n_tr, 40);
        chk("R10 ready after single run", ready, 1);

        // ID sweep: low nibble is don't-care
        for (int lo = 0; lo < 16; lo++) begin
            n_tr = 0; id_val = 16'h9220 | 16'(lo);
            pulse_start(); wait_idle();
            chk("R2 accepted id ready", ready, 1);
            chk("R2 accepted id count", n_tr, 40);
            chk("R3 status read second", lop[1], 2);
        end

        // ID sweep: any masked bit flipped is rejected
        for (int b = 4; b < 16; b++) begin
            n_tr = 0; id_val = 16'h9220 ^ (16'h0001 << b);
            pulse_start(); wait_idle(); cyc(20);
            chk("R2 rejected id fault", fault, 1);
            chk("R2 rejected id ready", ready, 0);
            chk("R2 rejected id powered", powered, 0);
            chk("R2 rejected id stops", n_tr, 1);
        end

        // Recovery from fault
        n_tr = 0; id_val = 16'h922F;
        pulse_start(); wait_idle();
        chk("R10 restart clears fault", fault, 0);
        chk("R10 restart ready", ready, 1);

        // Error during power-off keeps the power state
        n_tr = 0; err_at = 1; pulse_off(); wait_idle(); cyc(10);
        err_at = -1;
        chk("R9 error fault", fault, 1);
        chk("R9 error ready", ready, 0);
        chk("R9 powered unchanged", powered, 1);
        chk("R9 sequence stopped", n_tr, 2);
        n_tr = 0; pulse_off(); pulse_on(); cyc(30);
        chk("R10 power requests ignored in fault", n_tr, 0);

        // Error during bring-up
        n_tr = 0; err_at = 5; pulse_start(); wait_idle(); cyc(10);
        err_at = -1;
        chk("R9 init error fault", fault, 1);
        chk("R9 init error stops", n_tr, 6);
        chk("R9 init error powered", powered, 0);

        n_tr = 0; pulse_start(); wait_idle();
        chk("R10 recovery after error", ready, 1);
        chk("R10 recovery count", n_tr, 40);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule